// File: doc/BRIEF.md
# I/O Cycle Chip-Select Hold Extender

This block runs one peripheral I/O cycle at a time for a bus master that works on a fast memory clock. The address, direction and write data belong to the memory clock domain. Chip select is timed in a separate I/O clock domain that runs at a fixed frequency. A request is captured on the memory clock and passed to the I/O domain through a toggle and a two-flop synchroniser. Chip select is then asserted for a parameterised number of I/O clocks. Completion returns to the memory domain by the same toggle method.

When the memory clock is much faster than the I/O clock, completion can come back to the memory domain very soon after chip select drops. The address would then change almost as soon as the select ends. A timing register holds a hold-extend flag in its most significant bit. When that flag is set, one idle I/O clock is inserted after chip select goes low and before completion is signalled. This gives the peripheral a full I/O period of address hold. Write data is captured when the request is accepted, so the master's data bus is free for other traffic while the cycle runs.

Top module: `iocyc_hold_ext`

## Requirements
- R1: After reset, `busy`, `done` and `io_cs` are low, and the hold-extend flag (bit 7 of the timing register) is 0.
- R2: When `busy` is low, `req_valid` high at a memory clock edge accepts the request. From the next cycle, `busy` is high and `io_addr`, `io_write` and `io_wdata` carry the request's address, direction (1 = write) and data.
- R3: While `busy` is high, `req_valid` is ignored. The held outputs do not change, and no extra chip-select pulse is produced.
- R4: Each accepted request gives exactly one `io_cs` pulse. The pulse stays high for exactly `ACT_CYC` consecutive I/O clocks.
- R5: `io_addr`, `io_write` and `io_wdata` stay stable from acceptance until `done`, including while chip select is high and when it falls. Changes on `req_wdata` after acceptance have no effect.
- R6: With the hold flag at 0, the completion handshake starts on the same I/O edge that drops `io_cs`. No further I/O clock edge occurs between the fall of `io_cs` and the fall of `busy`, provided the memory clock is at least five times faster.
- R7: With the hold flag at 1, exactly one more I/O clock edge passes between the fall of `io_cs` and the fall of `busy`.
- R8: `io_rdata` is sampled on the I/O edge that ends the active phase. The sampled value appears on `rd_data` in the cycle where `done` is high.
- R9: `done` is a single-cycle pulse. It is high in the first cycle after `busy` falls, and only then.
- R10: Bits 6..0 of the timing register have no effect on cycle timing. Writing 0x7F behaves the same as writing 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Memory clock |
| mrst | input | 1 | Synchronous active-high reset, memory domain |
| ioclk | input | 1 | I/O clock |
| iorst | input | 1 | Synchronous active-high reset, I/O domain |
| req_valid | input | 1 | Cycle request strobe |
| req_addr | input | AW | Request address |
| req_write | input | 1 | Request direction, 1 = write |
| req_wdata | input | DW | Request write data |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_wdata | input | 8 | Timing register write value (bit 7 = hold extend) |
| busy | output | 1 | A cycle is outstanding |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Read data captured for the completed cycle |
| io_addr | output | AW | Held peripheral address |
| io_write | output | 1 | Held peripheral direction |
| io_wdata | output | DW | Held peripheral write data |
| io_cs | output | 1 | Chip select, I/O clock domain |
| io_rdata | input | DW | Peripheral read data |

## Verification
The two events that can land close together are the fall of chip select in the I/O domain and the completion of the cycle in the memory domain. With the hold flag clear, both fall within the same I/O period. The bench runs a memory clock five times faster than the I/O clock with staggered edges. It counts I/O edges between the observed fall of `io_cs` and the fall of `busy`, and expects 0 with the flag clear and 1 with it set. A request presented during the completion cycle is also checked: it must not be taken early or lost.

// File: rtl/iocyc_pkg.sv
package iocyc_pkg;
  typedef enum logic [1:0] {
    IO_IDLE = 2'd0,
    IO_ACT  = 2'd1,
    IO_HOLD = 2'd2
  } io_state_t;

  localparam int unsigned TREG_W    = 8;
  localparam int unsigned HOLD_BIT  = 7;
endpackage

// File: rtl/iocyc_sync.sv
module iocyc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/iocyc_mem_side.sv
module iocyc_mem_side
  import iocyc_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  input  logic              cfg_wr,
  input  logic [TREG_W-1:0] cfg_wdata,
  input  logic              ack_s,
  input  logic [DW-1:0]     rdata_io,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     io_addr,
  output logic              io_write,
  output logic [DW-1:0]     io_wdata,
  output logic              req_tog,
  output logic              hold_lat
);
  logic [TREG_W-1:0] treg;
  logic              ack_p;
  logic              ack_edge;
  logic              accept;

  assign ack_edge = ack_s ^ ack_p;
  assign accept   = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      treg     <= '0;
      ack_p    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      io_addr  <= '0;
      io_write <= 1'b0;
      io_wdata <= '0;
      req_tog  <= 1'b0;
      hold_lat <= 1'b0;
    end else begin
      ack_p <= ack_s;
      done  <= 1'b0;
      if (cfg_wr) treg <= cfg_wdata;
      if (accept) begin
        io_addr  <= req_addr;
        io_write <= req_write;
        io_wdata <= req_wdata;
        hold_lat <= treg[HOLD_BIT];
        req_tog  <= ~req_tog;
        busy     <= 1'b1;
      end else if (busy && ack_edge) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        rd_data <= rdata_io;
      end
    end
  end

  // R3: a request seen while busy leaves the held address untouched
  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(io_addr) && $stable(io_wdata));

  // R5: held outputs stay put for the whole outstanding cycle
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(io_addr) && $stable(io_write) && $stable(io_wdata)));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: completion coincides with busy falling
  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: done never overlaps an outstanding cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/iocyc_io_seq.sv
module iocyc_io_seq
  import iocyc_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned ACT_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_s,
  input  logic          hold_en,
  input  logic [DW-1:0] io_rdata,
  output logic          io_cs,
  output logic          ack_tog,
  output logic [DW-1:0] rdata_q
);
  localparam int unsigned CW = (ACT_CYC > 1) ? $clog2(ACT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACT_CYC - 1);

  io_state_t     state;
  logic          req_p;
  logic [CW-1:0] cnt;
  logic          start;

  assign start = (req_s ^ req_p) && (state == IO_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IO_IDLE;
      req_p   <= 1'b0;
      cnt     <= '0;
      io_cs   <= 1'b0;
      ack_tog <= 1'b0;
      rdata_q <= '0;
    end else begin
      req_p <= req_s;
      unique case (state)
        IO_IDLE: begin
          if (start) begin
            state <= IO_ACT;
            io_cs <= 1'b1;
            cnt   <= LAST;
          end
        end
        IO_ACT: begin
          if (cnt == '0) begin
            io_cs   <= 1'b0;
            rdata_q <= io_rdata;
            if (hold_en) begin
              state <= IO_HOLD;
            end else begin
              state   <= IO_IDLE;
              ack_tog <= ~ack_tog;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        IO_HOLD: begin
          state   <= IO_IDLE;
          ack_tog <= ~ack_tog;
        end
        default: state <= IO_IDLE;
      endcase
    end
  end

  // independent run-length counter for the chip-select pulse
  logic [CW:0] cs_run;
  always_ff @(posedge clk) begin
    if (rst)        cs_run <= '0;
    else if (io_cs) cs_run <= cs_run + 1'b1;
    else            cs_run <= '0;
  end

  // R4: chip select never exceeds its programmed width
  p_cs_max_r4: assert property (@(posedge clk) disable iff (rst)
    io_cs |-> (cs_run < (CW+1)'(ACT_CYC)));

  // R4: chip select never ends early
  p_cs_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(io_cs) |-> ($past(cs_run) == (CW+1)'(ACT_CYC - 1)));

  // R7: the extra period only happens with the flag set and select released
  p_hold_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (state == IO_HOLD) |-> (!io_cs && hold_en));

  // R6: without the flag, the handshake toggles together with select falling
  p_nohold_ack_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(io_cs) && !hold_en) |-> (ack_tog != $past(ack_tog)));
endmodule

// File: rtl/iocyc_hold_ext.sv
module iocyc_hold_ext
  import iocyc_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 16,
  parameter int unsigned ACT_CYC = 3,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic          mclk,
  input  logic          mrst,
  input  logic          ioclk,
  input  logic          iorst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] io_addr,
  output logic          io_write,
  output logic [DW-1:0] io_wdata,
  output logic          io_cs,
  input  logic [DW-1:0] io_rdata
);
  logic          req_tog, req_s;
  logic          ack_tog, ack_s;
  logic          hold_lat;
  logic [DW-1:0] rdata_q;

  iocyc_mem_side #(.AW(AW), .DW(DW)) u_mem (
    .clk(mclk), .rst(mrst),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ack_s(ack_s), .rdata_io(rdata_q),
    .busy(busy), .done(done), .rd_data(rd_data),
    .io_addr(io_addr), .io_write(io_write), .io_wdata(io_wdata),
    .req_tog(req_tog), .hold_lat(hold_lat)
  );

  iocyc_sync #(.STAGES(SYNC_ST)) u_req_sync (
    .clk(ioclk), .rst(iorst), .d(req_tog), .q(req_s)
  );

  iocyc_io_seq #(.DW(DW), .ACT_CYC(ACT_CYC)) u_io (
    .clk(ioclk), .rst(iorst), .req_s(req_s), .hold_en(hold_lat),
    .io_rdata(io_rdata), .io_cs(io_cs), .ack_tog(ack_tog), .rdata_q(rdata_q)
  );

  iocyc_sync #(.STAGES(SYNC_ST)) u_ack_sync (
    .clk(mclk), .rst(mrst), .d(ack_tog), .q(ack_s)
  );
endmodule

// File: tb/test_iocyc_hold_ext.sv
module test_iocyc_hold_ext;
  localparam int CLK_PERIOD = 4;
  localparam int IO_PERIOD  = 20;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int ACT = 3;

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          hold;
  } item_t;

  logic mclk = 0, ioclk = 0, mrst = 1, iorst = 1;
  logic req_valid = 0, req_write = 0, cfg_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [7:0] cfg_wdata = '0;
  logic busy, done, io_write, io_cs;
  logic [DW-1:0] rd_data, io_wdata, io_rdata;
  logic [AW-1:0] io_addr;

  int tests = 0, fails = 0;
  int accepted = 0, pulses = 0;
  int io_edges = 0;
  logic cur_hold = 0;
  item_t sbq[$];
  item_t cur;
  bit finished = 0;

  iocyc_hold_ext #(.AW(AW), .DW(DW), .ACT_CYC(ACT)) i_iocyc_hold_ext (
    .mclk(mclk), .mrst(mrst), .ioclk(ioclk), .iorst(iorst),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .io_addr(io_addr), .io_write(io_write), .io_wdata(io_wdata),
    .io_cs(io_cs), .io_rdata(io_rdata)
  );

  function automatic logic [DW-1:0] periph(input logic [AW-1:0] a);
    return {4'h5, a} ^ 16'h3C3C;
  endfunction
  assign io_rdata = periph(io_addr);

  always #(CLK_PERIOD/2) mclk = ~mclk;
  initial begin
    #1;
    forever #(IO_PERIOD/2) ioclk = ~ioclk;
  end
  always @(posedge ioclk) io_edges++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge mclk);
    cfg_wr = 1; cfg_wdata = v;
    @(negedge mclk);
    cfg_wr = 0;
    cur_hold = v[7];
  endtask

  // driver: accepts one request and pushes the expected cycle
  task automatic do_req(input logic [AW-1:0] a, input logic w,
                        input logic [DW-1:0] d, input bit stall);
    item_t it;
    @(negedge mclk);
    while (busy) @(negedge mclk);
    req_valid = 1; req_addr = a; req_write = w; req_wdata = d;
    it.addr = a; it.wr = w; it.wdata = d; it.rdata = periph(a); it.hold = cur_hold;
    sbq.push_back(it);
    accepted++;
    @(negedge mclk);
    req_valid = 0;
    req_wdata = ~d;
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    chk(io_addr === a && io_write === w && io_wdata === d, "R2 held outputs",
        io_addr, a);
    if (stall) begin
      for (int k = 0; k < 3; k++) begin
        req_valid = 1; req_addr = ~a; req_wdata = 16'hDEAD;
        @(negedge mclk);
        chk(io_addr === a && io_wdata === d, "R3 request while busy ignored",
            io_addr, a);
      end
      req_valid = 0;
    end
  endtask

  // monitor: pops expected items at chip-select rise and judges completion
  logic cs_q = 0, busy_q = 0, done_q = 0;
  int rise_e = 0, fall_e = 0;
  bit active = 0;
  always @(negedge mclk) begin
    if (!mrst) begin
      if (done_q) chk(done === 1'b0, "R9 done single cycle", done, 0);
      if (io_cs && !cs_q) begin
        pulses++;
        rise_e = io_edges;
        if (sbq.size() == 0) begin
          chk(0, "R3 unexpected chip-select pulse", 1, 0);
        end else begin
          cur = sbq.pop_front();
          active = 1;
          chk(io_addr === cur.addr && io_write === cur.wr && io_wdata === cur.wdata,
              "R5 outputs at select rise", io_wdata, cur.wdata);
        end
      end
      if (!io_cs && cs_q && active) begin
        fall_e = io_edges;
        chk(fall_e - rise_e == ACT, "R4 chip-select width", fall_e - rise_e, ACT);
        chk(io_addr === cur.addr && io_wdata === cur.wdata,
            "R5 outputs stable at select fall", io_addr, cur.addr);
      end
      if (!busy && busy_q && active) begin
        active = 0;
        chk(done === 1'b1, "R9 done with busy fall", done, 1);
        chk(rd_data === cur.rdata, "R8 read data", rd_data, cur.rdata);
        if (cur.hold)
          chk(io_edges - fall_e == 1, "R7 extra hold period", io_edges - fall_e, 1);
        else
          chk(io_edges - fall_e == 0, "R6 R10 minimal delay", io_edges - fall_e, 0);
      end
      if (done && !done_q && busy_q === 1'b0)
        chk(0, "R9 done without cycle", 1, 0);
      cs_q = io_cs; busy_q = busy; done_q = done;
    end
  end

  initial begin
    repeat (100000) @(posedge mclk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(posedge ioclk);
    @(negedge mclk);
    mrst = 0; iorst = 0;
    @(negedge mclk);
    chk(busy === 1'b0, "R1 busy reset", busy, 0);
    chk(done === 1'b0, "R1 done reset", done, 0);
    chk(io_cs === 1'b0, "R1 cs reset", io_cs, 0);
    // R1: flag resets to 0, so the first cycles take the minimal path
    do_req(12'h123, 1'b1, 16'hBEEF, 1);
    do_req(12'hFFF, 1'b0, 16'h0000, 0);
    // R7: hold extend on
    cfg(8'h80);
    do_req(12'h0A5, 1'b1, 16'h1234, 1);
    do_req(12'h800, 1'b0, 16'hFFFF, 0);
    // R10: low bits only
    cfg(8'h7F);
    do_req(12'h001, 1'b1, 16'h5A5A, 0);
    // back to back: request waiting through the completion cycle
    cfg(8'h80);
    do_req(12'h3C3, 1'b0, 16'h0F0F, 0);
    do_req(12'hC3C, 1'b1, 16'hF0F0, 0);
    while (busy || sbq.size() != 0) @(negedge mclk);
    repeat (4) @(negedge mclk);
    chk(pulses == accepted, "R3 R4 one pulse per accepted request", pulses, accepted);
    chk(io_cs === 1'b0 && busy === 1'b0, "R2 idle at end", busy, 0);
    report();
  end
endmodule